// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Fractional Dither

This block is one channel of a timer. It sits beside a shared free-running counter, which is supplied from outside together with its overflow and update-event pulses. In compare mode, software stores a threshold through a simple write strobe. A registered pulse-width output is high while the counter is below the live threshold. The live threshold either follows each write at once or is refreshed from the stored value only when an update event arrives.

In dither mode the stored word is read as a 16-bit integer threshold plus a 4-bit fraction. The channel counts counter overflows in a 4-bit period index. Across each run of 16 periods it raises the threshold by one in exactly as many periods as the fraction value, and it spreads those periods evenly. This gives a mean duty resolution finer than one counter step.

In capture mode the channel keeps the counter value seen on each capture pulse and sets a flag. A read clears the flag. Software writes have no effect in this mode. Reads return the stored word in a registered read-data port.

Top module: `tmrc_channel`

## Requirements
- R1: After reset, `rdata_o`, `oc_o` and `cap_flag_o` are 0, and the channel is in compare mode with immediate loading and dither off. The stored word, the live threshold and the period index are all 0.
- R2: With immediate loading (`ctl_preload_i`=0 latched), a write updates both the stored word and the live threshold at the same clock edge. An update pulse has no effect in this case.
- R3: With deferred loading (`ctl_preload_i`=1 latched), a write changes only the stored word. The live threshold takes the stored word at each `upd_i` pulse. When a write and `upd_i` fall in the same cycle, the live threshold takes the value stored before that write.
- R4: `oc_o` is registered. At each edge it takes 1 when the counter value is below the effective threshold and 0 otherwise, so a threshold of 0 keeps it low. It is 0 while in capture mode.
- R5: With dither off, bits 15:0 form the threshold. A write stores bits 19:16 as zero, so they read back as zero.
- R6: With dither on, bits 19:4 are the integer threshold and bits 3:0 are the fraction F. The period index advances by one (mod 16) on each `ovf_i` pulse. The effective threshold is the integer plus 1 when the bit-reversed index is less than F, and the integer alone otherwise.
- R7: In capture mode, `cap_i` stores the counter into bits 15:0 with bits 19:16 zero when dither is off. With dither on, it stores the counter into bits 19:4 with bits 3:0 zero. Writes are ignored. `cap_i` has no effect in compare mode.
- R8: `rd_i` loads `rdata_o`, one edge later, with the stored word as it stands after that same edge, including a capture or write made in the same cycle. Without `rd_i`, `rdata_o` holds its value.
- R9: `cap_flag_o` is set by a capture in capture mode and cleared by `rd_i`. If both fall in the same cycle, the read wins and the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we_i | input | 1 | Latch the three control bits below |
| ctl_input_i | input | 1 | 1 = capture mode, 0 = compare mode |
| ctl_preload_i | input | 1 | 1 = defer threshold loading to update events |
| ctl_dither_i | input | 1 | 1 = integer in bits 19:4, fraction in bits 3:0 |
| wr_i | input | 1 | Write strobe for the stored word |
| wdata_i | input | 20 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 20 | Registered read data |
| cnt_i | input | 16 | Shared counter value |
| ovf_i | input | 1 | Counter overflow pulse (counter wraps after this cycle) |
| upd_i | input | 1 | Update event pulse |
| cap_i | input | 1 | Capture event pulse |
| oc_o | output | 1 | Registered compare output |
| cap_flag_o | output | 1 | Capture pending flag |

## Verification
Two pairs of functions can fall in the same cycle. In capture mode, a capture can meet a read. In deferred compare mode, a write can meet an update event. The bench provokes the first by raising `cap_i` and `rd_i` together, and it judges that `rdata_o` shows the fresh counter value while the flag stays clear. It provokes the second by pulsing `wr_i` and `upd_i` together, and it judges from `oc_o` over the following counter periods that the threshold switched to the older stored value, with the new one arriving only at the next update.

// File: rtl/tmrc_pkg.sv
package tmrc_pkg;
  typedef struct packed {
    logic in_mode;
    logic preload;
    logic dither;
  } tmrc_ctl_t;
endpackage

// File: rtl/tmrc_regs.sv
module tmrc_regs
  import tmrc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we_i,
  input  tmrc_ctl_t        ctl_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             upd_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output tmrc_ctl_t        ctl_o,
  output logic [REG_W-1:0] active_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             cap_flag_o
);
  tmrc_ctl_t        ctl_q;
  logic [REG_W-1:0] store_q, active_q, rdata_q, store_nxt, wr_val, cap_val;
  logic             flag_q, cap_hit, wr_hit;

  assign cap_hit = cap_i & ctl_q.in_mode;
  assign wr_hit  = wr_i & ~ctl_q.in_mode;
  assign wr_val  = ctl_q.dither ? wdata_i : {{FRAC_W{1'b0}}, wdata_i[CNT_W-1:0]};
  assign cap_val = ctl_q.dither ? {cnt_i, {FRAC_W{1'b0}}} : {{FRAC_W{1'b0}}, cnt_i};

  always_comb begin
    store_nxt = store_q;
    if (cap_hit)     store_nxt = cap_val;
    else if (wr_hit) store_nxt = wr_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      store_q  <= '0;
      active_q <= '0;
      rdata_q  <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (ctl_we_i) ctl_q <= ctl_i;
      store_q <= store_nxt;
      if (!ctl_q.in_mode) begin
        if (ctl_q.preload) begin
          if (upd_i) active_q <= store_q;
        end else if (wr_i) begin
          active_q <= wr_val;
        end
      end
      if (rd_i) rdata_q <= store_nxt;
      if (rd_i)         flag_q <= 1'b0;
      else if (cap_hit) flag_q <= 1'b1;
    end
  end

  assign ctl_o      = ctl_q;
  assign active_o   = active_q;
  assign rdata_o    = rdata_q;
  assign cap_flag_o = flag_q;

  // R3: deferred loading keeps the live threshold until an update pulse
  a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.preload && !upd_i) |=> $stable(active_q));
  // R7: capture mode ignores writes
  a_r7_read_only: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.in_mode && !cap_i) |=> $stable(store_q));
  // R5: dither-off writes clear the top bits
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.dither && !ctl_q.in_mode && wr_i) |=> (store_q[REG_W-1:CNT_W] == '0));
  // R9: flag set by a lone capture, cleared by a read
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    (cap_i && ctl_q.in_mode && !rd_i) |=> cap_flag_o);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> !cap_flag_o);
endmodule

// File: rtl/tmrc_dither.sv
module tmrc_dither #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_i,
  input  logic             dither_i,
  input  logic [REG_W-1:0] active_i,
  output logic [CNT_W:0]   eff_o
);
  logic [FRAC_W-1:0] idx_q, idx_rev;
  logic              bump;

  always_ff @(posedge clk) begin
    if (rst)        idx_q <= '0;
    else if (ovf_i) idx_q <= idx_q + 1'b1;
  end

  for (genvar i = 0; i < FRAC_W; i++) begin : g_rev
    assign idx_rev[i] = idx_q[FRAC_W-1-i];
  end

  assign bump  = idx_rev < active_i[FRAC_W-1:0];
  assign eff_o = dither_i ? ({1'b0, active_i[REG_W-1:FRAC_W]} + {{CNT_W{1'b0}}, bump})
                          : {1'b0, active_i[CNT_W-1:0]};

  // R6: period index steps by one per overflow
  a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> ((idx_q - $past(idx_q)) == FRAC_W'(1)));
  a_r6_index_hold: assert property (@(posedge clk) disable iff (rst)
    !ovf_i |=> $stable(idx_q));
endmodule

// File: rtl/tmrc_compare.sv
module tmrc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   eff_i,
  output logic             oc_o
);
  logic oc_q;

  always_ff @(posedge clk) begin
    if (rst) oc_q <= 1'b0;
    else     oc_q <= enable_i & ({1'b0, cnt_i} < eff_i);
  end

  assign oc_o = oc_q;

  // R4: zero threshold or capture mode keeps the output low
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (eff_i == '0 || !enable_i) |=> !oc_o);
  // R4: threshold beyond any counter value keeps it high
  a_r4_full_high: assert property (@(posedge clk) disable iff (rst)
    (enable_i && eff_i[CNT_W]) |=> oc_o);
endmodule

// File: rtl/tmrc_channel.sv
module tmrc_channel
  import tmrc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we_i,
  input  logic             ctl_input_i,
  input  logic             ctl_preload_i,
  input  logic             ctl_dither_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             upd_i,
  input  logic             cap_i,
  output logic             oc_o,
  output logic             cap_flag_o
);
  tmrc_ctl_t        ctl_in, ctl;
  logic [REG_W-1:0] active;
  logic [CNT_W:0]   eff;

  assign ctl_in = '{in_mode: ctl_input_i, preload: ctl_preload_i, dither: ctl_dither_i};

  tmrc_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we_i), .ctl_i(ctl_in),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .upd_i(upd_i),
    .cap_i(cap_i), .cnt_i(cnt_i), .ctl_o(ctl), .active_o(active),
    .rdata_o(rdata_o), .cap_flag_o(cap_flag_o)
  );

  tmrc_dither #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dither (
    .clk(clk), .rst(rst), .ovf_i(ovf_i), .dither_i(ctl.dither),
    .active_i(active), .eff_o(eff)
  );

  tmrc_compare #(.CNT_W(CNT_W)) u_compare (
    .clk(clk), .rst(rst), .enable_i(~ctl.in_mode), .cnt_i(cnt_i),
    .eff_i(eff), .oc_o(oc_o)
  );
endmodule

// File: tb/tmrc_channel_bench.sv
module tmrc_channel_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        ctl_we = 0, ctl_input = 0, ctl_preload = 0, ctl_dither = 0;
  logic        wr = 0, rd = 0, upd = 0, cap = 0, ovf = 0;
  logic [19:0] wdata = '0;
  logic [15:0] cnt = '0;
  logic [19:0] rdata;
  logic        oc, cap_flag;

  int checks = 0, fails = 0, cnt_top = 39;
  string cur_req = "R1";

  // reference model state
  int  m_store = 0, m_act = 0, m_rdata = 0, m_idx = 0;
  bit  m_in = 0, m_pre = 0, m_dith = 0, m_flag = 0, m_oc = 0;

  always #(PERIOD/2) clk = ~clk;

  tmrc_channel u_tmrc_channel (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we), .ctl_input_i(ctl_input),
    .ctl_preload_i(ctl_preload), .ctl_dither_i(ctl_dither),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata),
    .cnt_i(cnt), .ovf_i(ovf), .upd_i(upd), .cap_i(cap),
    .oc_o(oc), .cap_flag_o(cap_flag)
  );

  function automatic int rev4(int v);
    int r = 0;
    for (int i = 0; i < 4; i++) r |= ((v >> i) & 1) << (3 - i);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_store = 0; m_act = 0; m_rdata = 0; m_idx = 0;
      m_in = 0; m_pre = 0; m_dith = 0; m_flag = 0; m_oc = 0;
    end else begin
      int eff, wv, nstore;
      bit capt;
      eff = m_dith ? ((m_act >> 4) + ((rev4(m_idx) < (m_act & 15)) ? 1 : 0))
                   : (m_act & 'hFFFF);
      m_oc = !m_in && (int'(cnt) < eff);
      wv = m_dith ? int'(wdata) : (int'(wdata) & 'hFFFF);
      capt = cap && m_in;
      nstore = m_store;
      if (capt)             nstore = m_dith ? (int'(cnt) << 4) : int'(cnt);
      else if (wr && !m_in) nstore = wv;
      if (!m_in) begin
        if (m_pre) begin if (upd) m_act = m_store; end
        else if (wr) m_act = wv;
      end
      if (rd) m_rdata = nstore;
      if (rd) m_flag = 0; else if (capt) m_flag = 1;
      m_store = nstore;
      if (ovf) m_idx = (m_idx + 1) % 16;
      if (ctl_we) begin m_in = ctl_input; m_pre = ctl_preload; m_dith = ctl_dither; end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rdata !== 20'(m_rdata)) begin
      fails++;
      $display("FAIL %s rdata_o actual %h expected %h", cur_req, rdata, 20'(m_rdata));
    end
    checks++;
    if (oc !== m_oc) begin
      fails++;
      $display("FAIL %s oc_o actual %b expected %b at cnt %0d", cur_req, oc, m_oc, cnt);
    end
    checks++;
    if (cap_flag !== m_flag) begin
      fails++;
      $display("FAIL %s cap_flag_o actual %b expected %b", cur_req, cap_flag, m_flag);
    end
  end

  task automatic cycle(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      wr = 0; rd = 0; upd = 0; cap = 0; ctl_we = 0;
      cnt = (int'(cnt) >= cnt_top) ? 16'd0 : cnt + 16'd1;
      ovf = (int'(cnt) == cnt_top);
    end
  endtask

  task automatic set_ctl(bit i, bit p, bit d);
    ctl_we = 1; ctl_input = i; ctl_preload = p; ctl_dither = d;
    cycle();
  endtask

  task automatic write(int v, bit with_upd = 0);
    wr = 1; wdata = 20'(v); upd = with_upd;
    cycle();
  endtask

  task automatic read();
    rd = 1;
    cycle();
  endtask

  initial begin
    repeat (3) cycle();
    rst = 0;
    cur_req = "R1"; cycle(4);
    cur_req = "R2"; write(20); cycle(80);
    upd = 1; cycle(); cycle(40);
    cur_req = "R4"; write(0); cycle(45);
    write(50); cycle(45);
    cur_req = "R5"; write('hF0019); read(); cycle(45);
    cur_req = "R3"; set_ctl(0, 1, 0); write(8); cycle(45);
    upd = 1; cycle(); cycle(45);
    write(30, 1); cycle(45);
    upd = 1; cycle(); cycle(45);
    cur_req = "R6"; cnt_top = 19; set_ctl(0, 0, 1);
    write((10 << 4) | 3); cycle(330);
    write((10 << 4) | 15); cycle(330);
    write((7 << 4) | 0); read(); cycle(100);
    write('hFFFFF); cycle(40);
    cur_req = "R7"; cnt_top = 39; set_ctl(1, 0, 0); cycle(5);
    cap = 1; cycle(); cycle(3); read();
    write(12345); read(); cycle(7);
    set_ctl(1, 0, 1); cycle(3); cap = 1; cycle(); read();
    cur_req = "R9"; cap = 1; cycle(); cycle(6); read(); cycle(3);
    cur_req = "R8"; cycle(4); cap = 1; rd = 1; cycle(); cycle(5);
    cap = 1; cycle(); rd = 1; cap = 1; cycle(); cycle(4);
    cur_req = "R7"; set_ctl(0, 0, 0); cap = 1; cycle(); read(); cycle(45);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired during %s actual running expected finished", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule